// File: doc/BRIEF.md
# Self-Repairing Cell Position and Configuration Unit

Each cell of a self-repairing array runs this unit. It computes the cell's position from the cell below it and picks the cell's configuration from a fixed table indexed by that position. The position is a 6-bit value. Bits [5:3] hold the column X and bits [2:0] hold the row Y. A healthy cell keeps the column it receives from the south. It adds one to the row, modulo 8. A bottom-row cell has its south input tied to row 7, so it lands on row 0.

A cell whose own self-test fails takes its whole row out of service. The fault flag is combined with directional kill flags and forwarded east and west. Every cell in that row then becomes transparent. A transparent cell passes the incoming position northward unchanged, so each row above renumbers itself one lower and takes over the work of the row beneath. Position and health are registered on the cell clock. The configuration word is looked up combinationally from those registers.

The table stores only the words of this cell's own column, selected by a parameter, plus one transparent word. A cell that is not healthy gets the transparent word. So does any position outside the used rows, or in a different column.

Top module: `cell_diff_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the following edge leaves `coord_o` = 0 and `ok_o` = 1.
- R2: A cell whose row is not killed registers `coord_o` = {south X, south Y + 1} at the next edge. X is bits [5:3] and Y is bits [2:0].
- R3: The row increment wraps modulo 8, so a south Y of 7 gives Y = 0. This is how the bottom row is addressed.
- R4: When `fault_i`, `kill_from_west_i` or `kill_from_east_i` is high, the next edge registers `coord_o` = `south_coord_i` unchanged and `ok_o` = 0.
- R5: Kill forwarding is combinational and directional. `kill_to_east_o` = `fault_i` | `kill_from_west_i`, and `kill_to_west_o` = `fault_i` | `kill_from_east_i`.
- R6: `ok_o` returns to 1 at the first edge at which all three kill sources are low.
- R7: When `ok_o` is 0, `cfg_o` = 0x0A200 whatever the position.
- R8: When `ok_o` = 1, X = COLUMN and Y < ROWS, `cfg_o` is the gene for row Y. Its fields are:
  - [16:15] = COLUMN[1:0]
  - [14:13] = Y[1:0]
  - [12:11] = 2'b10
  - [10:9] = 2'b00
  - [8:6] = (Y+1) mod 8
  - [5] = Y[0]
  - [4:2] = COLUMN
  - [1:0] = 2'b11
- R9: When `ok_o` = 1 and either X ≠ COLUMN or Y ≥ ROWS, `cfg_o` = 0x0A200.
- R10: Reset takes precedence over a fault present at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst | input | 1 | Synchronous reset, active high |
| south_coord_i | input | 6 | Position from the south neighbour ({X,Y}) |
| fault_i | input | 1 | Local self-test fault |
| kill_from_west_i | input | 1 | Row-kill flag arriving from the west neighbour |
| kill_from_east_i | input | 1 | Row-kill flag arriving from the east neighbour |
| coord_o | output | 6 | Registered position sent north |
| ok_o | output | 1 | Registered health status |
| kill_to_east_o | output | 1 | Row-kill flag forwarded east |
| kill_to_west_o | output | 1 | Row-kill flag forwarded west |
| cfg_o | output | 17 | Configuration word |

## Verification
The bench drives a south row of 7 to check the wrap to row 0. A design without modular arithmetic would give a bottom row of 8, or a carry into X. Kills arrive separately from each side, from the local fault, and together with reset. A design that forwards a flag in the wrong direction, or lets a fault beat reset, would miss the transparent pass-through or the reset values. Positions at the last used row, at the first unused row, and in foreign columns probe the table edges. An off-by-one limit or a missing column test would return a gene where the transparent word belongs. Fault pulses followed by healthy cycles show whether health recovers after exactly one edge.

// File: rtl/cdu_pkg.sv
package cdu_pkg;
  localparam int AXW   = 3;
  localparam int CRDW  = 2 * AXW;
  localparam int CFGW  = 17;
  localparam logic [CFGW-1:0] CFG_TRANSPARENT = 17'h0A200;

  typedef struct packed {
    logic [AXW-1:0] x;
    logic [AXW-1:0] y;
  } coord_t;

  typedef struct packed {
    logic [1:0] rt_w;
    logic [1:0] rt_e;
    logic [1:0] rt_s;
    logic [1:0] rt_n;
    logic [2:0] in_r;
    logic       reg_en;
    logic [2:0] in_l;
    logic [1:0] sel;
  } cfg_t;

  // Position of a healthy cell: same column, one row further north.
  function automatic coord_t step_north(coord_t s);
    coord_t r;
    r.x = s.x;
    r.y = s.y + AXW'(1);
    return r;
  endfunction

  // Gene of one row of the configured column.
  function automatic cfg_t gene_word(logic [AXW-1:0] col, logic [AXW-1:0] row);
    cfg_t w;
    w.rt_w   = col[1:0];
    w.rt_e   = row[1:0];
    w.rt_s   = 2'b10;
    w.rt_n   = 2'b00;
    w.in_r   = row + 3'd1;
    w.reg_en = row[0];
    w.in_l   = col;
    w.sel    = 2'b11;
    return w;
  endfunction
endpackage

// File: rtl/cdu_status.sv
module cdu_status (
  input  logic fault_i,
  input  logic kill_from_west_i,
  input  logic kill_from_east_i,
  output logic kill_to_east_o,
  output logic kill_to_west_o,
  output logic row_kill_o
);
  // Directional forwarding keeps the row free of combinational loops.
  assign kill_to_east_o = fault_i | kill_from_west_i;
  assign kill_to_west_o = fault_i | kill_from_east_i;
  assign row_kill_o     = fault_i | kill_from_west_i | kill_from_east_i;
endmodule

// File: rtl/cdu_coord.sv
module cdu_coord
  import cdu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   row_kill_i,
  input  coord_t south_i,
  output coord_t coord_q,
  output logic   ok_q
);
  coord_t coord_d;

  always_comb begin
    if (row_kill_i) coord_d = south_i;
    else            coord_d = step_north(south_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coord_q <= '0;
      ok_q    <= 1'b1;
    end else begin
      coord_q <= coord_d;
      ok_q    <= ~row_kill_i;
    end
  end
endmodule

// File: rtl/cdu_genome.sv
module cdu_genome
  import cdu_pkg::*;
#(
  parameter int COLUMN = 2,
  parameter int ROWS   = 5
) (
  input  logic            ok_i,
  input  coord_t          coord_i,
  output logic [CFGW-1:0] cfg_o
);
  localparam logic [AXW-1:0] COL_ID = AXW'(COLUMN);

  logic            col_hit;
  logic [CFGW-1:0] row_word;

  assign col_hit = (coord_i.x == COL_ID);

  always_comb begin
    row_word = CFG_TRANSPARENT;
    for (int r = 0; r < ROWS; r++) begin
      if (int'(coord_i.y) == r) row_word = gene_word(COL_ID, AXW'(r));
    end
  end

  assign cfg_o = (ok_i && col_hit) ? row_word : CFG_TRANSPARENT;
endmodule

// File: rtl/cell_diff_unit.sv
module cell_diff_unit
  import cdu_pkg::*;
#(
  parameter int COLUMN = 2,
  parameter int ROWS   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CRDW-1:0] south_coord_i,
  input  logic            fault_i,
  input  logic            kill_from_west_i,
  input  logic            kill_from_east_i,
  output logic [CRDW-1:0] coord_o,
  output logic            ok_o,
  output logic            kill_to_east_o,
  output logic            kill_to_west_o,
  output logic [CFGW-1:0] cfg_o
);
  logic   row_kill;
  coord_t coord_q;
  logic   ok_q;

  cdu_status u_status (
    .fault_i          (fault_i),
    .kill_from_west_i (kill_from_west_i),
    .kill_from_east_i (kill_from_east_i),
    .kill_to_east_o   (kill_to_east_o),
    .kill_to_west_o   (kill_to_west_o),
    .row_kill_o       (row_kill)
  );

  cdu_coord u_coord (
    .clk        (clk),
    .rst        (rst),
    .row_kill_i (row_kill),
    .south_i    (coord_t'(south_coord_i)),
    .coord_q    (coord_q),
    .ok_q       (ok_q)
  );

  cdu_genome #(.COLUMN(COLUMN), .ROWS(ROWS)) u_genome (
    .ok_i    (ok_q),
    .coord_i (coord_q),
    .cfg_o   (cfg_o)
  );

  assign coord_o = coord_q;
  assign ok_o    = ok_q;
endmodule

// File: rtl/cdu_chk.sv
module cdu_chk
  import cdu_pkg::*;
#(
  parameter int COLUMN = 2,
  parameter int ROWS   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [CRDW-1:0] south_coord_i,
  input logic            fault_i,
  input logic            row_kill,
  input logic [CRDW-1:0] coord_o,
  input logic            ok_o,
  input logic            kill_to_east_o,
  input logic            kill_to_west_o,
  input logic [CFGW-1:0] cfg_o
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  reset_state_chk: assert property (@(posedge clk) rst_d |-> (coord_o == '0 && ok_o));

  // R2
  healthy_step_chk: assert property (@(posedge clk) disable iff (rst)
    !row_kill |=> (coord_o[5:3] == $past(south_coord_i[5:3]) &&
                   coord_o[2:0] == 3'($past(south_coord_i[2:0]) + 3'd1) && ok_o));

  // R4
  transparent_pass_chk: assert property (@(posedge clk) disable iff (rst)
    row_kill |=> (coord_o == $past(south_coord_i) && !ok_o));

  // R5
  fault_forward_chk: assert property (@(posedge clk) disable iff (rst)
    fault_i |-> (kill_to_east_o && kill_to_west_o));

  // R7
  dead_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    !ok_o |-> cfg_o == CFG_TRANSPARENT);

  // R8
  gene_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (ok_o && int'(coord_o[5:3]) == COLUMN && int'(coord_o[2:0]) < ROWS) |-> cfg_o[1:0] == 2'b11);

  // R9
  foreign_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (ok_o && (int'(coord_o[5:3]) != COLUMN || int'(coord_o[2:0]) >= ROWS)) |-> cfg_o == CFG_TRANSPARENT);
endmodule

bind cell_diff_unit cdu_chk #(.COLUMN(COLUMN), .ROWS(ROWS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .south_coord_i  (south_coord_i),
  .fault_i        (fault_i),
  .row_kill       (row_kill),
  .coord_o        (coord_o),
  .ok_o           (ok_o),
  .kill_to_east_o (kill_to_east_o),
  .kill_to_west_o (kill_to_west_o),
  .cfg_o          (cfg_o)
);

// File: tb/test_cell_diff_unit.sv
`timescale 1ns/1ps
module test_cell_diff_unit;
  localparam int COL  = 2;
  localparam int ROWS = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  south = '0;
  logic        fault = 1'b0, kw = 1'b0, ke = 1'b0;
  logic [5:0]  coord_o;
  logic        ok_o, k_e, k_w;
  logic [16:0] cfg_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_coord = 0;
  int exp_ok = 1;

  always #4 clk = ~clk;

  cell_diff_unit #(.COLUMN(COL), .ROWS(ROWS)) i_cell_diff_unit (
    .clk(clk), .rst(rst), .south_coord_i(south), .fault_i(fault),
    .kill_from_west_i(kw), .kill_from_east_i(ke), .coord_o(coord_o),
    .ok_o(ok_o), .kill_to_east_o(k_e), .kill_to_west_o(k_w), .cfg_o(cfg_o)
  );

  function automatic int ref_cfg(int ok, int c);
    int x = c / 8;
    int y = c % 8;
    if (ok == 0 || x != COL || y >= ROWS) return 'h0A200;
    return (COL % 4) * 32768 + (y % 4) * 8192 + 2 * 2048 +
           ((y + 1) % 8) * 64 + (y % 2) * 32 + COL * 4 + 3;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle: compare registered outputs, apply new inputs, predict next state.
  task automatic cycle(input logic r, input logic [5:0] s, input logic f,
                       input logic w, input logic e, input string tag);
    @(negedge clk);
    check({tag, " coord"}, int'(coord_o), exp_coord);
    check({tag, " ok"}, int'(ok_o), exp_ok);
    check(exp_ok == 0 ? "R7 cfg" : "R8/R9 cfg", int'(cfg_o), ref_cfg(exp_ok, exp_coord));
    rst = r; south = s; fault = f; kw = w; ke = e;
    #1;
    check("R5 east", int'(k_e), int'(f | w));
    check("R5 west", int'(k_w), int'(f | e));
    if (r) begin
      exp_coord = 0; exp_ok = 1;
    end else if (f | w | e) begin
      exp_coord = int'(s); exp_ok = 0;
    end else begin
      exp_coord = (int'(s) / 8) * 8 + ((int'(s) % 8) + 1) % 8;
      exp_ok = 1;
    end
  endtask

  initial begin
    // R1: reset values
    cycle(1'b1, 6'd0, 1'b0, 1'b0, 1'b0, "R1");
    cycle(1'b1, 6'd0, 1'b0, 1'b0, 1'b0, "R1");
    // R2 and R8: walk every row of the own column, including the last used row
    for (int y = 0; y < 8; y++)
      cycle(1'b0, 6'(COL * 8 + y), 1'b0, 1'b0, 1'b0, "R2");
    // R3: south row 7 wraps to row 0
    cycle(1'b0, 6'(COL * 8 + 7), 1'b0, 1'b0, 1'b0, "R3");
    cycle(1'b0, 6'(5 * 8 + 7), 1'b0, 1'b0, 1'b0, "R3");
    // R9: foreign columns
    cycle(1'b0, 6'(1 * 8 + 1), 1'b0, 1'b0, 1'b0, "R9");
    cycle(1'b0, 6'(3 * 8 + 0), 1'b0, 1'b0, 1'b0, "R9");
    // R4: kill from each source, then R6 recovery
    cycle(1'b0, 6'(COL * 8 + 2), 1'b1, 1'b0, 1'b0, "R4");
    cycle(1'b0, 6'(COL * 8 + 1), 1'b0, 1'b0, 1'b0, "R6");
    cycle(1'b0, 6'(COL * 8 + 3), 1'b0, 1'b1, 1'b0, "R4");
    cycle(1'b0, 6'(COL * 8 + 4), 1'b0, 1'b0, 1'b1, "R4");
    cycle(1'b0, 6'(COL * 8 + 0), 1'b0, 1'b0, 1'b0, "R6");
    cycle(1'b0, 6'(COL * 8 + 0), 1'b0, 1'b1, 1'b1, "R4");
    cycle(1'b0, 6'(COL * 8 + 3), 1'b0, 1'b0, 1'b0, "R6");
    // R10: reset beats a simultaneous fault
    cycle(1'b1, 6'(COL * 8 + 3), 1'b1, 1'b0, 1'b0, "R10");
    cycle(1'b0, 6'(COL * 8 + 2), 1'b0, 1'b0, 1'b0, "R10");
    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [5:0] s = 6'($urandom);
      if (i % 3 == 0) s[5:3] = 3'(COL);
      cycle(1'b0, s, 1'(($urandom % 7) == 0), 1'(($urandom % 9) == 0),
            1'(($urandom % 9) == 0), "R2/R4");
    end
    cycle(1'b0, 6'd0, 1'b0, 1'b0, 1'b0, "R2");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule